// File: doc/BRIEF.md
# Warp Lane-Group Issue Sequencer

This block issues the instructions of one thread block onto a narrow bank of execution lanes. The block's threads are grouped into warps of a fixed size, and the lane bank is narrower than a warp. Each warp instruction therefore leaves the sequencer as several back-to-back beats. Each beat carries one group of threads, one thread per lane. For a given instruction index the sequencer sends every beat of warp 0, then every beat of warp 1, and so on through the resident warps. Only after the last warp does it move to the next instruction index.

A start pulse latches the block's thread count and the number of instructions to issue. Every beat shows the warp index, the lane-group index, the half-warp index, the instruction index and a per-lane active mask. A beat is consumed only when the downstream ready input is high. A one-cycle done pulse closes the run.

Top module: `warp_issue_seq`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, valid_o, busy_o and done_o are all low.
- R2: A start_i pulse seen while idle, with nonzero thread and instruction counts, makes valid_o and busy_o high in the next cycle. The first beat shows warp 0, group 0 and instruction 0. A start_i with a zero thread count or a zero instruction count is ignored.
- R3: Within a warp, the lane groups are issued in the order 0, 1, 2, 3. Group g covers threads 8g to 8g+7 of the warp. half_o equals bit 1 of group_o.
- R4: For each instruction index, warps 0 to ceil(threads/32)-1 are issued in ascending order. The instruction index then advances by one.
- R5: mask_o bit i is 1 exactly when warp*32 + group*8 + i is below the thread count. All four groups of the last warp are issued, even when a group's mask is all zero.
- R6: When valid_o is high and ready_i is low, warp_o, group_o, instr_o and mask_o hold their values and valid_o stays high.
- R7: After the final beat is accepted, done_o is high for exactly one cycle. In that same cycle valid_o and busy_o are low.
- R8: A start_i pulse while busy_o is high has no effect on the running sequence.
- R9: A thread count above 512 is treated as 512, which is 16 warps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| thread_cnt_i | input | 10 | Threads in the block, sampled at start |
| instr_cnt_i | input | 8 | Instructions to issue, sampled at start |
| ready_i | input | 1 | Downstream accepts the current beat |
| valid_o | output | 1 | A beat is presented |
| warp_o | output | 4 | Warp index of the beat |
| group_o | output | 2 | Lane-group index within the warp |
| half_o | output | 1 | Half-warp index |
| instr_o | output | 8 | Instruction index of the beat |
| mask_o | output | 8 | Active lanes of the beat |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the last beat |

## Verification
The hardest state to reach is the final beat of the final warp on the last instruction while ready_i is toggling. At that point the wrap of all three counters, the done pulse and a possible new start pulse all meet in one cycle. The stimulus reaches it with runs of small instruction counts and thread counts that end on a partial warp, where random ready gaps land on the final beat. Start pulses with different counts are also injected while busy_o is high. Directed runs at 1, 33, 512 and 600 threads cover the mask edges and the clamp.

// File: rtl/warp_seq_pkg.sv
package warp_seq_pkg;
  localparam int unsigned DEF_LANES     = 8;
  localparam int unsigned DEF_WARP_SIZE = 32;
  localparam int unsigned DEF_MAX_WARPS = 16;
  localparam int unsigned DEF_INSTR_W   = 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/wis_ctrl.sv
module wis_ctrl #(
  parameter int unsigned THR_W       = 10,
  parameter int unsigned WARP_W      = 4,
  parameter int unsigned INSTR_W     = 8,
  parameter int unsigned WARP_SHIFT  = 5,
  parameter int unsigned MAX_THREADS = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [THR_W-1:0]   thread_cnt_i,
  input  logic [INSTR_W-1:0] instr_cnt_i,
  input  logic               fire_i,
  input  logic               last_i,
  output logic               launch_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [THR_W-1:0]   thr_q_o,
  output logic [WARP_W-1:0]  last_warp_o,
  output logic [INSTR_W-1:0] last_instr_o
);
  import warp_seq_pkg::*;

  seq_state_e        state_q;
  logic [THR_W-1:0]  thr_eff;
  logic [THR_W-1:0]  thr_m1;

  // clamp to the resident limit
  assign thr_eff  = (thread_cnt_i > THR_W'(MAX_THREADS)) ? THR_W'(MAX_THREADS) : thread_cnt_i;
  assign thr_m1   = thr_eff - THR_W'(1);
  assign launch_o = (state_q == ST_IDLE) && start_i &&
                    (thread_cnt_i != '0) && (instr_cnt_i != '0);
  assign busy_o   = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      done_o       <= 1'b0;
      thr_q_o      <= '0;
      last_warp_o  <= '0;
      last_instr_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (launch_o) begin
        state_q      <= ST_RUN;
        thr_q_o      <= thr_eff;
        last_warp_o  <= WARP_W'(thr_m1 >> WARP_SHIFT);
        last_instr_o <= instr_cnt_i - INSTR_W'(1);
      end else if (busy_o && fire_i && last_i) begin
        state_q <= ST_IDLE;
        done_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wis_cursor.sv
module wis_cursor #(
  parameter int unsigned GROUPS  = 4,
  parameter int unsigned GRP_W   = 2,
  parameter int unsigned WARP_W  = 4,
  parameter int unsigned INSTR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic [WARP_W-1:0]  last_warp_i,
  input  logic [INSTR_W-1:0] last_instr_i,
  output logic [GRP_W-1:0]   group_o,
  output logic [WARP_W-1:0]  warp_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic               last_o
);
  logic grp_wrap, warp_wrap, instr_wrap;

  assign grp_wrap   = (group_o == GRP_W'(GROUPS - 1));
  assign warp_wrap  = (warp_o == last_warp_i);
  assign instr_wrap = (instr_o == last_instr_i);
  assign last_o     = grp_wrap && warp_wrap && instr_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_o <= '0;
      warp_o  <= '0;
      instr_o <= '0;
    end else if (clr_i) begin
      group_o <= '0;
      warp_o  <= '0;
      instr_o <= '0;
    end else if (adv_i) begin
      if (!grp_wrap) begin
        group_o <= group_o + GRP_W'(1);
      end else begin
        group_o <= '0;
        if (!warp_wrap) begin
          warp_o <= warp_o + WARP_W'(1);
        end else begin
          warp_o  <= '0;
          instr_o <= instr_o + INSTR_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wis_mask.sv
module wis_mask #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned WARP_SIZE = 32,
  parameter int unsigned THR_W     = 10,
  parameter int unsigned WARP_W    = 4,
  parameter int unsigned GRP_W     = 2
) (
  input  logic [WARP_W-1:0] warp_i,
  input  logic [GRP_W-1:0]  group_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic [LANES-1:0]  mask_o
);
  localparam int unsigned IDX_W = THR_W + 2;

  logic [IDX_W-1:0] base;
  assign base = IDX_W'(warp_i) * IDX_W'(WARP_SIZE) + IDX_W'(group_i) * IDX_W'(LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mask_o[i] = (base + IDX_W'(i)) < IDX_W'(thr_i);
  end
endmodule

// File: rtl/warp_issue_seq.sv
module warp_issue_seq
  import warp_seq_pkg::*;
#(
  parameter int unsigned LANES     = DEF_LANES,
  parameter int unsigned WARP_SIZE = DEF_WARP_SIZE,
  parameter int unsigned MAX_WARPS = DEF_MAX_WARPS,
  parameter int unsigned INSTR_W   = DEF_INSTR_W,
  localparam int unsigned GROUPS      = WARP_SIZE / LANES,
  localparam int unsigned GRP_W       = $clog2(GROUPS),
  localparam int unsigned WARP_W      = $clog2(MAX_WARPS),
  localparam int unsigned MAX_THREADS = MAX_WARPS * WARP_SIZE,
  localparam int unsigned THR_W       = $clog2(MAX_THREADS + 1),
  localparam int unsigned WARP_SHIFT  = $clog2(WARP_SIZE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [THR_W-1:0]   thread_cnt_i,
  input  logic [INSTR_W-1:0] instr_cnt_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [WARP_W-1:0]  warp_o,
  output logic [GRP_W-1:0]   group_o,
  output logic               half_o,
  output logic [INSTR_W-1:0] instr_o,
  output logic [LANES-1:0]   mask_o,
  output logic               busy_o,
  output logic               done_o
);
  logic               launch, fire, last;
  logic [THR_W-1:0]   thr_q;
  logic [WARP_W-1:0]  last_warp;
  logic [INSTR_W-1:0] last_instr;

  assign valid_o = busy_o;
  assign fire    = valid_o && ready_i;
  assign half_o  = group_o[GRP_W-1];

  wis_ctrl #(
    .THR_W(THR_W), .WARP_W(WARP_W), .INSTR_W(INSTR_W),
    .WARP_SHIFT(WARP_SHIFT), .MAX_THREADS(MAX_THREADS)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .thread_cnt_i, .instr_cnt_i,
    .fire_i(fire), .last_i(last), .launch_o(launch),
    .busy_o, .done_o, .thr_q_o(thr_q),
    .last_warp_o(last_warp), .last_instr_o(last_instr)
  );

  wis_cursor #(
    .GROUPS(GROUPS), .GRP_W(GRP_W), .WARP_W(WARP_W), .INSTR_W(INSTR_W)
  ) u_cursor (
    .clk_i, .rst_ni, .clr_i(launch), .adv_i(fire),
    .last_warp_i(last_warp), .last_instr_i(last_instr),
    .group_o, .warp_o, .instr_o, .last_o(last)
  );

  wis_mask #(
    .LANES(LANES), .WARP_SIZE(WARP_SIZE), .THR_W(THR_W),
    .WARP_W(WARP_W), .GRP_W(GRP_W)
  ) u_mask (
    .warp_i(warp_o), .group_i(group_o), .thr_i(thr_q), .mask_o
  );
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned WARP_W  = 4,
  parameter int unsigned GRP_W   = 2,
  parameter int unsigned INSTR_W = 8,
  parameter int unsigned GROUPS  = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               ready_i,
  input logic               valid_o,
  input logic [WARP_W-1:0]  warp_o,
  input logic [GRP_W-1:0]   group_o,
  input logic [INSTR_W-1:0] instr_o,
  input logic [LANES-1:0]   mask_o,
  input logic               busy_o,
  input logic               done_o
);
  p_first_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (warp_o == '0) && (group_o == '0) && (instr_o == '0));

  p_group_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ready_i && (group_o != GRP_W'(GROUPS - 1)))
      |=> (group_o == $past(group_o) + GRP_W'(1)) && (warp_o == $past(warp_o)));

  p_lane0_live_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (warp_o == '0) && (group_o == '0)) |-> mask_o[0]);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> valid_o && $stable(warp_o) && $stable(group_o)
                               && $stable(instr_o) && $stable(mask_o));

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o && !busy_o);

  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !ready_i) |=> busy_o && $stable(instr_o) && $stable(warp_o));
endmodule

bind warp_issue_seq wis_checker #(
  .LANES(LANES), .WARP_W(WARP_W), .GRP_W(GRP_W), .INSTR_W(INSTR_W), .GROUPS(GROUPS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_i(ready_i),
  .valid_o(valid_o), .warp_o(warp_o), .group_o(group_o), .instr_o(instr_o),
  .mask_o(mask_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/warp_issue_seq_test.sv
`timescale 1ns/1ps
module warp_issue_seq_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] thread_cnt_i = '0;
  logic [7:0] instr_cnt_i = '0;
  logic       ready_i = 1'b0;
  logic       valid_o, half_o, busy_o, done_o;
  logic [3:0] warp_o;
  logic [1:0] group_o;
  logic [7:0] instr_o, mask_o;

  int total = 0;
  int bad = 0;

  // model state
  bit m_busy = 0, m_done = 0, m_last_rdy = 1;
  int m_tc, m_lw, m_li, m_w, m_g, m_i;

  warp_issue_seq uut (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] exp_mask(int tc, int w, int g);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (w * 32 + g * 8 + i) < tc;
    return m;
  endfunction

  task automatic chk(string req, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_outs();
    string pos;
    pos = m_last_rdy ? "R4" : "R6";
    chk("R2 valid", valid_o, m_busy);
    chk("R2 busy", busy_o, m_busy);
    chk("R7 done", done_o, m_done);
    if (m_busy) begin
      chk({pos, " warp"}, warp_o, m_w);
      chk({"R3 group ", pos}, group_o, m_g);
      chk("R3 half", half_o, (m_g >> 1) & 1);
      chk({pos, " instr"}, instr_o, m_i);
      chk("R5 mask", mask_o, exp_mask(m_tc, m_w, m_g));
    end
  endtask

  task automatic step(bit st, int tc, int ic, bit rdy);
    start_i = st; thread_cnt_i = 10'(tc); instr_cnt_i = 8'(ic); ready_i = rdy;
    m_done = 0;
    m_last_rdy = rdy;
    if (m_busy) begin
      if (rdy) begin
        if (m_g == 3 && m_w == m_lw && m_i == m_li) begin
          m_busy = 0; m_done = 1;
        end else if (m_g < 3) m_g++;
        else begin
          m_g = 0;
          if (m_w < m_lw) m_w++;
          else begin m_w = 0; m_i++; end
        end
      end
    end else if (st && tc > 0 && ic > 0) begin
      m_busy = 1;
      m_tc = (tc > 512) ? 512 : tc;  // R9 clamp
      m_lw = (m_tc - 1) / 32;
      m_li = ic - 1;
      m_w = 0; m_g = 0; m_i = 0;
    end
    @(negedge clk_i);
    check_outs();
  endtask

  // rdy_pct: chance of ready per beat; inject: start pulses while busy (R8)
  task automatic run(int tc, int ic, int rdy_pct, bit inject);
    step(1, tc, ic, ($urandom % 100) < rdy_pct);
    while (m_busy) begin
      bit st;
      st = inject && (($urandom % 4) == 0);
      step(st, st ? 1 + ($urandom % 600) : 0, st ? 1 + ($urandom % 3) : 0,
           ($urandom % 100) < rdy_pct);
    end
    step(0, 0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", valid_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_outs();
    // R2 zero counts ignored
    step(1, 0, 3, 1);
    step(1, 40, 0, 1);
    step(0, 0, 0, 1);
    // R4 two warps, two instructions, full ready
    run(64, 2, 100, 0);
    // R5 single thread, all-zero groups still issued
    run(1, 1, 100, 0);
    // R5 partial second warp
    run(33, 2, 70, 0);
    // R9 full and over-limit counts
    run(512, 1, 100, 0);
    run(600, 1, 80, 0);
    // R6 heavy backpressure; R8 start while busy
    run(100, 3, 30, 1);
    run(64, 2, 50, 1);
    // constrained random runs
    for (int k = 0; k < 25; k++) begin
      run(1 + ($urandom % 520), 1 + ($urandom % 4), 20 + ($urandom % 81), ($urandom % 2) == 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule